// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor

This block turns one 128-bit ciphertext block back into plaintext under a 128-bit key, using the inverse AES cipher in electronic-codebook fashion. One block is handled at a time. Key and ciphertext arrive as two 64-bit beats framed by a single pulse on `load`. A one-cycle `start` pulse launches the computation, and `done` rises after a fixed number of cycles with the plaintext on `data_out`.

Internally, a single inverse-round datapath is reused once per cycle. Before the rounds begin, the key is expanded forward, one round key per cycle, into a bank of eleven registers. The rounds then read that bank from the last key down to the first. The controller is a six-state machine:

- ST_IDLE (after reset) moves to ST_EXPAND on `start`.
- ST_EXPAND stays for ten cycles, producing round keys 1 to 10, then moves to ST_WHITEN.
- ST_WHITEN XORs the block with round key 10 and moves to ST_ROUND.
- ST_ROUND runs nine full inverse rounds with keys 9 down to 1, then moves to ST_LAST.
- ST_LAST omits the column mixing, adds round key 0 and moves to ST_DONE.
- ST_DONE holds the result and returns to ST_EXPAND on the next `start`.

Top module: `aes128_inv_core`

## Requirements
- R1: Key and ciphertext bits 127:64 are captured from `key_in`/`data_in` on the clock edge where `load` is first seen high. Bits 63:0 are captured on the edge where `load` is first seen low again.
- R2: `start` is accepted only in ST_IDLE or ST_DONE. After the edge that accepts it, `done` is low.
- R3: `done` rises on the 21st rising edge after the edge that accepted `start`. These are 10 key-expansion cycles, 1 whitening cycle, 9 full rounds and 1 final round.
- R4: `data_out` equals the inverse AES-128 cipher of the loaded block: XOR with round key 10, nine rounds of inverse row shift, inverse substitution, key addition and inverse column mixing, then a last round without column mixing that ends with round key 0. Known answer: key 000102030405060708090a0b0c0d0e0f with ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a gives 00112233445566778899aabbccddeeff.
- R5: While no `start` is applied, `done` stays high and `data_out` stays unchanged.
- R6: A `start` pulse during ST_EXPAND, ST_WHITEN, ST_ROUND or ST_LAST is ignored. It changes neither the latency nor the result, and produces no extra result.
- R7: A load during a running decryption does not change that decryption's result. The newly loaded block and key are used by the next accepted `start`.
- R8: While `rst_n` is low, `done` is low and `data_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Load framing pulse: rising edge takes upper halves, falling edge lower halves |
| start | input | 1 | Launches a decryption when idle or done |
| data_in | input | 64 | Ciphertext half |
| key_in | input | 64 | Key half |
| done | output | 1 | High when `data_out` holds a finished plaintext |
| data_out | output | 128 | Recovered plaintext |

## Verification
Two things can happen in the same cycle here: a running decryption, and either a load of the input buffers or a further `start` pulse. The bench loads a complete new key and ciphertext while rounds are in progress. It then requires that the running result still matches the old block and that the next launch decrypts the new one. It also pulses `start` in the middle of a run and requires that exactly one result appears, still at 21 cycles from the accepted pulse. Every result is compared against published known-answer vectors through a queue of expected plaintexts.

// File: rtl/aes_inv_pkg.sv
`timescale 1ns/1ps
package aes_inv_pkg;
    localparam int BLK_W         = 128;
    localparam int HALF_W        = BLK_W / 2;
    localparam int NROUNDS       = 10;
    localparam int NKEYS         = NROUNDS + 1;
    localparam int IDX_W         = $clog2(NKEYS);
    // expansion cycles + whitening + full rounds + last round
    localparam int START_TO_DONE = NROUNDS + 1 + (NROUNDS - 1) + 1;

    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [7:0]       byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXPAND,
        ST_WHITEN,
        ST_ROUND,
        ST_LAST,
        ST_DONE
    } phase_t;

    // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic byte_t xt(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gmul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t p;
        acc = '0;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xt(p);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254, zero maps to zero
    function automatic byte_t ginv(input byte_t a);
        byte_t r;
        byte_t s;
        r = 8'h01;
        s = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gmul(r, s);
            s = gmul(s, s);
        end
        return r;
    endfunction

    function automatic byte_t rl(input byte_t a, input int k);
        return byte_t'((a << k) | (a >> (8 - k)));
    endfunction

    function automatic byte_t sbox_fwd(input byte_t a);
        byte_t b;
        b = ginv(a);
        return b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
    endfunction

    function automatic byte_t sbox_inv(input byte_t a);
        return ginv(rl(a, 1) ^ rl(a, 3) ^ rl(a, 6) ^ 8'h05);
    endfunction
endpackage

// File: rtl/aes_inv_round.sv
`timescale 1ns/1ps
module aes_inv_round
    import aes_inv_pkg::*;
(
    input  blk_t state_i,
    input  blk_t rkey_i,
    input  logic mix_en_i,
    output blk_t state_o
);
    byte_t sb [16];
    byte_t ak [16];
    byte_t mc [16];

    // byte n sits at bits BLK_W-1-8n; column c holds bytes 4c..4c+3, row = n mod 4
    for (genvar c = 0; c < 4; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int DST = 4 * c + r;
            localparam int SRC = 4 * ((c - r + 4) % 4) + r;
            assign sb[DST] = sbox_inv(state_i[BLK_W-1-8*SRC -: 8]);
            assign ak[DST] = sb[DST] ^ rkey_i[BLK_W-1-8*DST -: 8];
            assign mc[DST] = gmul(ak[4*c + r],           8'h0e)
                           ^ gmul(ak[4*c + (r + 1) % 4], 8'h0b)
                           ^ gmul(ak[4*c + (r + 2) % 4], 8'h0d)
                           ^ gmul(ak[4*c + (r + 3) % 4], 8'h09);
            assign state_o[BLK_W-1-8*DST -: 8] = mix_en_i ? mc[DST] : ak[DST];
        end
    end
endmodule

// File: rtl/aes_inv_keysched.sv
`timescale 1ns/1ps
module aes_inv_keysched
    import aes_inv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_i,
    input  logic             step_i,
    input  blk_t             key_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output blk_t             rkey_o
);
    blk_t        bank [NKEYS];
    blk_t        last_q;
    blk_t        next_k;
    byte_t       rcon_q;
    byte_t       sw [4];
    logic [31:0] tw;

    // rotate the last word by one byte, then substitute
    for (genvar g = 0; g < 4; g++) begin : g_sub
        assign sw[g] = sbox_fwd(last_q[31-8*((g+1)%4) -: 8]);
    end

    assign tw = {sw[0] ^ rcon_q, sw[1], sw[2], sw[3]};

    always_comb begin
        next_k[127:96] = last_q[127:96] ^ tw;
        next_k[95:64]  = last_q[95:64]  ^ next_k[127:96];
        next_k[63:32]  = last_q[63:32]  ^ next_k[95:64];
        next_k[31:0]   = last_q[31:0]   ^ next_k[63:32];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            rcon_q <= 8'h01;
        end else if (seed_i) begin
            last_q <= key_i;
            rcon_q <= 8'h01;
        end else if (step_i) begin
            last_q <= next_k;
            rcon_q <= xt(rcon_q);
        end
    end

    for (genvar k = 0; k < NKEYS; k++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[k] <= '0;
            end else if (seed_i && k == 0) begin
                bank[k] <= key_i;
            end else if (step_i && wr_idx_i == IDX_W'(k)) begin
                bank[k] <= next_k;
            end
        end
    end

    always_comb begin
        rkey_o = '0;
        for (int k = 0; k < NKEYS; k++) begin
            if (rd_idx_i == IDX_W'(k)) rkey_o = bank[k];
        end
    end
endmodule

// File: rtl/aes_inv_ctrl.sv
`timescale 1ns/1ps
module aes_inv_ctrl
    import aes_inv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             seed_o,
    output logic             step_o,
    output logic             whiten_o,
    output logic             round_o,
    output logic             last_o,
    output logic             mix_o,
    output logic             done_o,
    output logic [IDX_W-1:0] widx_o,
    output logic [IDX_W-1:0] ridx_o
);
    phase_t           state_q, state_d;
    logic [IDX_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d = ST_EXPAND;
                    cnt_d   = IDX_W'(1);
                end
            end
            ST_EXPAND: begin
                if (cnt_q == IDX_W'(NROUNDS)) state_d = ST_WHITEN;
                else                          cnt_d   = cnt_q + IDX_W'(1);
            end
            ST_WHITEN: begin
                state_d = ST_ROUND;
                cnt_d   = IDX_W'(NROUNDS - 1);
            end
            ST_ROUND: begin
                cnt_d = cnt_q - IDX_W'(1);
                if (cnt_q == IDX_W'(1)) state_d = ST_LAST;
            end
            ST_LAST:  state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        seed_o   = 1'b0;
        step_o   = 1'b0;
        whiten_o = 1'b0;
        round_o  = 1'b0;
        last_o   = 1'b0;
        mix_o    = 1'b0;
        done_o   = 1'b0;
        widx_o   = cnt_q;
        ridx_o   = '0;
        unique case (state_q)
            ST_IDLE:   seed_o = start_i;
            ST_DONE: begin
                seed_o = start_i;
                done_o = 1'b1;
            end
            ST_EXPAND: step_o = 1'b1;
            ST_WHITEN: begin
                whiten_o = 1'b1;
                ridx_o   = IDX_W'(NROUNDS);
            end
            ST_ROUND: begin
                round_o = 1'b1;
                mix_o   = 1'b1;
                ridx_o  = cnt_q;
            end
            ST_LAST:   last_o = 1'b1;
            default:   done_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/aes128_inv_core.sv
`timescale 1ns/1ps
module aes128_inv_core
    import aes_inv_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         start,
    input  logic [63:0]  data_in,
    input  logic [63:0]  key_in,
    output logic         done,
    output logic [127:0] data_out
);
    logic             load_q;
    blk_t             ct_buf, key_buf, work_q, rnd_out, rkey;
    logic             seed, step, whiten, rnd, last, mix;
    logic [IDX_W-1:0] widx, ridx;

    // input buffers: upper halves on load rise, lower halves on load fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q  <= 1'b0;
            ct_buf  <= '0;
            key_buf <= '0;
        end else begin
            load_q <= load;
            if (load && !load_q) begin
                ct_buf[BLK_W-1:HALF_W]  <= data_in;
                key_buf[BLK_W-1:HALF_W] <= key_in;
            end else if (!load && load_q) begin
                ct_buf[HALF_W-1:0]  <= data_in;
                key_buf[HALF_W-1:0] <= key_in;
            end
        end
    end

    aes_inv_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .seed_o   (seed),
        .step_o   (step),
        .whiten_o (whiten),
        .round_o  (rnd),
        .last_o   (last),
        .mix_o    (mix),
        .done_o   (done),
        .widx_o   (widx),
        .ridx_o   (ridx)
    );

    aes_inv_keysched u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed_i   (seed),
        .step_i   (step),
        .key_i    (key_buf),
        .wr_idx_i (widx),
        .rd_idx_i (ridx),
        .rkey_o   (rkey)
    );

    aes_inv_round u_round (
        .state_i  (work_q),
        .rkey_i   (rkey),
        .mix_en_i (mix),
        .state_o  (rnd_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q   <= '0;
            data_out <= '0;
        end else begin
            if (seed)        work_q <= ct_buf;
            else if (whiten) work_q <= work_q ^ rkey;
            else if (rnd)    work_q <= rnd_out;
            if (last)        data_out <= rnd_out;
        end
    end
endmodule

// File: rtl/aes128_inv_core_chk.sv
`timescale 1ns/1ps
module aes128_inv_core_chk
    import aes_inv_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic done,
    input blk_t data_out
);
    localparam int AGE_W = $clog2(START_TO_DONE + 1) + 1;

    logic             busy_q;
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            age_q  <= '0;
        end else if (start && (!busy_q || done)) begin
            busy_q <= 1'b1;
            age_q  <= '0;
        end else if (busy_q && done) begin
            busy_q <= 1'b0;
        end else if (busy_q && age_q != '1) begin
            age_q <= age_q + AGE_W'(1);
        end
    end

    assert_done_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> !done);

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (busy_q && age_q == AGE_W'(START_TO_DONE)));

    // a stray start during a run must not shorten it (R6)
    assert_no_early_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && age_q < AGE_W'(START_TO_DONE)) |-> !done);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(data_out)));

    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> (!done && data_out == '0));
endmodule

bind aes128_inv_core aes128_inv_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .data_out (data_out)
);

// File: tb/aes128_inv_core_test.sv
`timescale 1ns/1ps
module aes128_inv_core_test;
    import aes_inv_pkg::*;

    localparam blk_t K1 = 128'h000102030405060708090a0b0c0d0e0f;
    localparam blk_t C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam blk_t P1 = 128'h00112233445566778899aabbccddeeff;
    localparam blk_t K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam blk_t C2 = 128'h3925841d02dc09fbdc118597196a0b32;
    localparam blk_t P2 = 128'h3243f6a8885a308d313198a2e0370734;
    localparam blk_t K3 = 128'h0;
    localparam blk_t C3 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    localparam blk_t P3 = 128'h0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        start = 1'b0;
    logic [63:0] data_in = '0;
    logic [63:0] key_in = '0;
    logic        done;
    blk_t        data_out;

    blk_t   exp_q[$];
    string  tag_q[$];
    int     n_checks = 0;
    int     n_fail = 0;
    int     n_results = 0;
    longint cyc = 0;
    longint t_go = 0;
    logic   done_prev = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    aes128_inv_core uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .start    (start),
        .data_in  (data_in),
        .key_in   (key_in),
        .done     (done),
        .data_out (data_out)
    );

    task automatic check(input bit ok, input string tag, input blk_t act, input blk_t exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every rising done
    always @(negedge clk) begin
        blk_t  e;
        string t;
        if (rst_n && done && !done_prev) begin
            n_results++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected extra result", data_out, '0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(data_out == e, t, data_out, e);
            end
            check(cyc - t_go == longint'(START_TO_DONE), "R3 start-to-done latency",
                  blk_t'(cyc - t_go), blk_t'(START_TO_DONE));
        end
        done_prev = done;
    end

    task automatic load_block(input blk_t key, input blk_t ct);
        @(negedge clk);
        load = 1'b1; data_in = ct[127:64]; key_in = key[127:64];
        @(negedge clk);
        load = 1'b0; data_in = ct[63:0];   key_in = key[63:0];
        @(negedge clk);
        data_in = '0; key_in = '0;
    endtask

    // driver: push the expected plaintext, then launch
    task automatic go(input blk_t pt, input string tag);
        logic was_done;
        exp_q.push_back(pt);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b1;
        was_done = done;
        @(negedge clk);
        start = 1'b0;
        t_go = cyc;
        if (was_done) check(done == 1'b0, "R2 done clears after accepted start", blk_t'(done), '0);
    endtask

    task automatic wait_results(input int n);
        wait (n_results >= n);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(done == 1'b0, "R8 done low in reset", blk_t'(done), '0);
        check(data_out == '0, "R8 data_out zero in reset", data_out, '0);
        rst_n = 1'b1;

        // R1 half order and R4 known answer
        load_block(K1, C1);
        go(P1, "R1 R4 known-answer vector");
        wait_results(1);

        // R5: hold without start
        repeat (8) @(negedge clk);
        check(done == 1'b1, "R5 done held", blk_t'(done), blk_t'(1));
        check(data_out == P1, "R5 data_out held", data_out, P1);

        load_block(K2, C2);
        go(P2, "R4 second key");
        wait_results(2);

        load_block(K3, C3);
        go(P3, "R4 all-zero key");
        wait_results(3);

        // R6: stray start in the middle of a run
        load_block(K1, C1);
        go(P1, "R6 result with stray start");
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_results(4);
        repeat (25) @(negedge clk);
        check(n_results == 4, "R6 single result", blk_t'(n_results), blk_t'(4));
        check(data_out == P1, "R6 result kept", data_out, P1);

        // R7: new block loaded while rounds run
        load_block(K2, C2);
        go(P2, "R7 running block unaffected by load");
        repeat (3) @(negedge clk);
        load_block(K3, C3);
        wait_results(5);
        go(P3, "R7 next start uses new load");
        wait_results(6);

        // R8: reset after a result
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R8 done cleared by reset", blk_t'(done), '0);
        check(data_out == '0, "R8 data_out cleared by reset", data_out, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule